// File: doc/BRIEF.md
# Command-Driven HDLC Frame Transmitter

This block serializes frames for a low-rate signalling channel. A controller loads data bytes into a small transmit FIFO and then writes a command byte. A transmit command releases the bytes that are already in the FIFO onto the line. When the same write also carries the message-end bit, those bytes close the frame. Long frames are built from several blocks, each released by its own transmit command.

In normal mode the block adds the opening flag and inserts a zero after every run of five ones. At message end it adds the frame check sequence and the closing flag. The frame check sequence can be switched off. An extended transparent mode sends only the raw bytes, with no flags, no check sequence and no stuffing. One bit leaves on `tx_o` for every cycle in which `bit_en_i` is high, least significant bit first. Between frames the line carries back-to-back flags. `tx_active_o` tells the controller when a frame is still being sent.

Top module: `hdlc_tx`

## Requirements
- R1: After reset, `tx_active_o` is 0, `fifo_cnt_o` is 0 and `tx_o` is 1. Once `bit_en_i` pulses begin, the line carries back-to-back 0x7E flag bytes, LSB first.
- R2: A command write takes effect through three bits of `cmd_i`. Bit 3 is transmit, bit 1 is message end (acted on only together with bit 3) and bit 0 is transmitter reset. Bits 7, 6, 5, 4 and 2 have no effect.
- R3: FIFO writes are accepted only while `fifo_cnt_o` is below the block size. The block size is 16 when `blk32_i`=0 and 32 when `blk32_i`=1. Any further write is dropped.
- R4: A non-transparent frame starts with one 0x7E opening flag, followed by the data bytes LSB first. After five consecutive 1s in data or check bits, one extra 0 is inserted. Flags are never stuffed.
- R5: When `crc_off_i`=0, message end appends the 16-bit check sequence and then one 0x7E closing flag. The check sequence uses polynomial x^16+x^12+x^5+1 with a preset of 0xFFFF, is sent complemented, low byte first, and its bits are stuffed.
- R6: When `crc_off_i`=1, the closing flag follows the last data byte directly.
- R7: A transmit command without message end lets the frame continue. Bytes released by a later transmit command follow in the same frame with no gap.
- R8: When `ext_mode_i`=1, the released bytes go out raw, aligned to the byte grid of the idle flags, with no flags, check sequence or stuffing around or inside them.
- R9: `tx_active_o` rises in the cycle after a transmit command. It falls after the last bit of the closing flag, or after the last raw byte in transparent mode.
- R10: If the released bytes run out before message end, the block sends 0xFF (a run of at least seven 1s), clears `tx_active_o` and returns to idle flags.
- R11: A transmitter reset empties the FIFO and clears `tx_active_o` in the next cycle. It drops the frame in progress, and the line then carries idle flags again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-rate enable, one line bit per high cycle |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 8 | Command byte |
| fifo_we_i | input | 1 | FIFO write strobe |
| fifo_wdata_i | input | 8 | FIFO write data |
| blk32_i | input | 1 | Block size select: 0 for 16 bytes, 1 for 32 bytes |
| crc_off_i | input | 1 | Suppress the check sequence |
| ext_mode_i | input | 1 | Extended transparent mode |
| fifo_cnt_o | output | $clog2(DEPTH+1) | Bytes held in the FIFO |
| tx_active_o | output | 1 | Transmitter busy |
| tx_o | output | 1 | Serial line output |

## Verification
The bench decodes the line on its own and compares each recovered frame with a check sequence it computes itself. Several corner cases are covered:
- Bytes full of ones. A design that stuffs wrongly, or stuffs flags, produces frames of the wrong length or false aborts.
- A frame split across two blocks. A design that closes or aborts at the block boundary shows up as a short frame.
- Underrun. A missing abort turns into an unexpected frame.
- Transparent mode, checked on the raw bit grid. Any stray flag or stuffed bit shifts the data off alignment.
- FIFO overfill, ignored command bits and a mid-frame reset, each checked through `fifo_cnt_o`, `tx_active_o` and the recovery frame that follows.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_DATA, PH_CRC1, PH_CRC2, PH_CLOSE, PH_ABORT
  } phase_e;

  localparam logic [7:0] FLAG_BYTE  = 8'h7E;
  localparam logic [7:0] ABORT_BYTE = 8'hFF;
  localparam int CMD_XMIT = 3;
  localparam int CMD_MEND = 1;
  localparam int CMD_XRST = 0;

  // reflected CCITT update, LSB of data first
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction
endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [CW-1:0] limit_i,
  input  logic          re_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] cnt_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          push;

  assign push    = we_i && (cnt_q < limit_i);
  assign rdata_o = mem_q[rp_q];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
      if (re_i) rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
      cnt_q <= cnt_q + CW'(push) - CW'(re_i);
    end
  end
endmodule

// File: rtl/hdlc_tx_ser.sv
module hdlc_tx_ser
  import hdlc_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic       clr_i,
  input  logic       start_i,
  input  logic       end_i,
  input  logic       avail_i,
  input  logic       ext_i,
  input  logic       crc_off_i,
  input  logic [7:0] byte_i,
  output logic       pop_o,
  output logic       done_o,
  output logic       tx_o
);
  phase_e      ph_q, nph;
  logic [7:0]  sh_q, nb;
  logic [2:0]  bcnt_q, ones_q;
  logic        stf_q, nstf, tx_q;
  logic [15:0] crc_q;
  logic        take, fin, crc_init, crc_upd, adv, stuff;

  assign stuff  = (ones_q == 3'd5);
  assign adv    = bit_en_i && !stuff && (bcnt_q == 3'd7) && !clr_i;
  assign pop_o  = adv && take;
  assign done_o = adv && fin;
  assign tx_o   = tx_q;

  // choose the byte that follows the current one
  always_comb begin
    nb = FLAG_BYTE; nstf = 1'b0; nph = ph_q;
    take = 1'b0; fin = 1'b0; crc_init = 1'b0; crc_upd = 1'b0;
    case (ph_q)
      PH_IDLE: if (start_i) begin
        if (ext_i) begin
          if (avail_i) begin nb = byte_i; take = 1'b1; nph = PH_DATA; end
        end else begin
          nph = PH_DATA; crc_init = 1'b1;
        end
      end
      PH_DATA: if (avail_i) begin
        nb = byte_i; take = 1'b1; nstf = !ext_i; crc_upd = 1'b1;
      end else if (end_i) begin
        if (ext_i) begin nph = PH_IDLE; fin = 1'b1; end
        else if (!crc_off_i) begin nb = ~crc_q[7:0]; nstf = 1'b1; nph = PH_CRC1; end
        else nph = PH_CLOSE;
      end else begin
        nb = ABORT_BYTE; nph = PH_ABORT;
      end
      PH_CRC1: begin nb = ~crc_q[15:8]; nstf = 1'b1; nph = PH_CRC2; end
      PH_CRC2: nph = PH_CLOSE;
      default: begin nph = PH_IDLE; fin = 1'b1; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= FLAG_BYTE; bcnt_q <= '0; stf_q <= 1'b0; ones_q <= '0;
      ph_q <= PH_IDLE;   crc_q <= '1;  tx_q <= 1'b1;
    end else if (clr_i) begin
      sh_q <= FLAG_BYTE; bcnt_q <= '0; stf_q <= 1'b0; ones_q <= '0;
      ph_q <= PH_IDLE;
    end else if (bit_en_i) begin
      if (stuff) begin
        tx_q   <= 1'b0;
        ones_q <= '0;
      end else begin
        tx_q   <= sh_q[0];
        ones_q <= (stf_q && sh_q[0]) ? ones_q + 3'd1 : '0;
        if (bcnt_q == 3'd7) begin
          sh_q <= nb; stf_q <= nstf; bcnt_q <= '0; ph_q <= nph;
          if (crc_init)     crc_q <= '1;
          else if (crc_upd) crc_q <= crc16_byte(crc_q, byte_i);
        end else begin
          sh_q   <= sh_q >> 1;
          bcnt_q <= bcnt_q + 3'd1;
        end
      end
    end
  end

  p_tx_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(tx_o));
  p_ones_max_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= 3'd5);
endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx
  import hdlc_tx_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int SMALL_BLK = 16,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_en_i,
  input  logic          cmd_we_i,
  input  logic [7:0]    cmd_i,
  input  logic          fifo_we_i,
  input  logic [7:0]    fifo_wdata_i,
  input  logic          blk32_i,
  input  logic          crc_off_i,
  input  logic          ext_mode_i,
  output logic [CW-1:0] fifo_cnt_o,
  output logic          tx_active_o,
  output logic          tx_o
);
  logic          xmit, mend, xrst;
  logic          active_q, end_q, pop, done;
  logic [CW-1:0] rel_q, cnt, limit;
  logic [7:0]    rbyte;
  logic          unused_cmd;

  assign xmit  = cmd_we_i && cmd_i[CMD_XMIT];
  assign mend  = cmd_we_i && cmd_i[CMD_MEND];
  assign xrst  = cmd_we_i && cmd_i[CMD_XRST];
  assign unused_cmd = ^{cmd_i[7:4], cmd_i[2]};
  assign limit = blk32_i ? CW'(DEPTH) : CW'(SMALL_BLK);

  hdlc_tx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk_i, .rst_ni, .clr_i(xrst), .we_i(fifo_we_i), .wdata_i(fifo_wdata_i),
    .limit_i(limit), .re_i(pop), .rdata_o(rbyte), .cnt_o(cnt)
  );

  // a transmit command releases everything already held in the FIFO
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0; end_q <= 1'b0; rel_q <= '0;
    end else if (xrst) begin
      active_q <= 1'b0; end_q <= 1'b0; rel_q <= '0;
    end else begin
      if (xmit)     rel_q <= cnt - CW'(pop);
      else if (pop) rel_q <= rel_q - CW'(1);
      active_q <= xmit || (active_q && !done);
      if (xmit && mend) end_q <= 1'b1;
      else if (done)    end_q <= 1'b0;
    end
  end

  hdlc_tx_ser u_ser (
    .clk_i, .rst_ni, .bit_en_i, .clr_i(xrst), .start_i(active_q), .end_i(end_q),
    .avail_i(rel_q != '0), .ext_i(ext_mode_i), .crc_off_i, .byte_i(rbyte),
    .pop_o(pop), .done_o(done), .tx_o
  );

  assign fifo_cnt_o  = cnt;
  assign tx_active_o = active_q;

  p_cnt_limit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt_o <= CW'(DEPTH));
  p_xrst_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && cmd_i[0] |=> !tx_active_o && fifo_cnt_o == '0);
  p_xmit_active_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && cmd_i[3] && !cmd_i[0] |=> tx_active_o);
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && !(cmd_we_i && cmd_i[3]) |=> !tx_active_o);
  p_pop_released_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |-> rel_q != '0 && fifo_cnt_o != '0);
endmodule

// File: tb/hdlc_tx_tb.sv
`timescale 1ns/1ps
module hdlc_tx_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_en = 1'b0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd = '0;
  logic       fifo_we = 1'b0;
  logic [7:0] fifo_wdata = '0;
  logic       blk32 = 1'b0, crc_off = 1'b0, ext_mode = 1'b0;
  logic [5:0] fifo_cnt;
  logic       tx_active, tx;

  hdlc_tx u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_en_i(bit_en), .cmd_we_i(cmd_we), .cmd_i(cmd),
    .fifo_we_i(fifo_we), .fifo_wdata_i(fifo_wdata), .blk32_i(blk32), .crc_off_i(crc_off),
    .ext_mode_i(ext_mode), .fifo_cnt_o(fifo_cnt), .tx_active_o(tx_active), .tx_o(tx)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic       raw [$];
  logic       rxb [$];
  logic [7:0] cur [$];
  int         exp_len [$];
  logic [7:0] exp_b [$];
  string      exp_tag [$];
  bit         mute = 1'b1;
  bit         en_q = 1'b0;
  int         div = 0;
  int         ones = 0;
  bit         in_frame = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_fcs(input logic [7:0] d [$]);
    logic [15:0] c = 16'hFFFF;
    logic fb;
    foreach (d[i]) for (int j = 0; j < 8; j++) begin
      fb = c[0] ^ d[i][j];
      c  = {1'b0, c[15:1]} ^ ({16{fb}} & 16'h8408);
    end
    return c;
  endfunction

  task automatic frame_end();
    int n, l, bad;
    logic [7:0] g, e;
    string t;
    n = rxb.size() - 7;
    if (n > 0) begin
      if (exp_len.size() == 0) chk(0, "R5 unexpected frame", n, 0);
      else begin
        l = exp_len.pop_front(); t = exp_tag.pop_front(); bad = 0;
        for (int i = 0; i < l; i++) begin
          e = exp_b.pop_front(); g = '0;
          for (int j = 0; j < 8; j++) if (8*i + j < n) g[j] = rxb[8*i + j];
          if (g !== e) bad++;
        end
        chk(l >= 0 && n == 8*l && bad == 0, t, n, 8*l);
      end
    end
    rxb.delete();
  endtask

  // scoreboard monitor: line decoder plus bit-enable generator
  always @(negedge clk) begin
    if (en_q && rst_ni) begin
      raw.push_back(tx);
      if (mute) begin
        ones = 0; in_frame = 0; rxb.delete();
      end else if (tx) begin
        ones++; rxb.push_back(1'b1);
        if (ones == 7 && in_frame) begin
          in_frame = 0; rxb.delete();
          if (exp_len.size() == 0) chk(0, "R10 unexpected abort", 1, 0);
          else begin
            void'(exp_tag.pop_front());
            chk(exp_len.pop_front() == -1, "R10 abort where frame expected", 1, 0);
          end
        end
      end else if (ones == 5) begin
        ones = 0;
      end else if (ones == 6) begin
        ones = 0;
        if (in_frame) frame_end(); else rxb.delete();
        in_frame = 1;
      end else begin
        ones = 0; rxb.push_back(1'b0);
      end
    end
    en_q   = (div == 3);
    bit_en = en_q;
    div    = (div + 1) % 4;
  end

  task automatic push(input logic [7:0] b, input bit keep);
    @(negedge clk); fifo_we = 1'b1; fifo_wdata = b;
    @(negedge clk); fifo_we = 1'b0;
    if (keep) cur.push_back(b);
  endtask

  task automatic wcmd(input logic [7:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd = c;
    @(negedge clk); cmd_we = 1'b0; cmd = '0;
  endtask

  task automatic expect_frame(input bit crc, input string tag);
    logic [15:0] f;
    f = ~ref_fcs(cur);
    foreach (cur[i]) exp_b.push_back(cur[i]);
    if (crc) begin exp_b.push_back(f[7:0]); exp_b.push_back(f[15:8]); end
    exp_len.push_back(cur.size() + (crc ? 2 : 0));
    exp_tag.push_back(tag);
    cur.delete();
  endtask

  task automatic wait_idle();
    int t = 0;
    while (tx_active && t < 20000) begin @(negedge clk); t++; end
    repeat (100) @(negedge clk);
  endtask

  function automatic logic [7:0] raw_byte(input int i);
    logic [7:0] b;
    for (int j = 0; j < 8; j++) b[j] = raw[8*i + j];
    return b;
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_ni = 1'b1;
    raw.delete();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int k;
    do_reset();
    // R1
    chk(tx_active == 0, "R1 active after reset", tx_active, 0);
    chk(fifo_cnt == 0, "R1 fifo empty after reset", fifo_cnt, 0);
    chk(tx == 1, "R1 line high after reset", tx, 1);
    repeat (80) @(negedge clk);
    chk(raw_byte(0) == 8'h7E && raw_byte(1) == 8'h7E, "R1 idle flags", raw_byte(1), 8'h7E);
    mute = 1'b0;

    // R4/R5: stuffing-heavy frame with check sequence
    push(8'hFF, 1); push(8'h7E, 1); push(8'h1F, 1); push(8'hF8, 1);
    expect_frame(1, "R4 R5 stuffed frame with crc");
    wcmd(8'h0A);
    chk(tx_active == 1, "R9 active after transmit", tx_active, 1);
    wait_idle();
    chk(tx_active == 0, "R9 active clears after close flag", tx_active, 0);

    // R6
    crc_off = 1'b1;
    push(8'h3C, 1); push(8'hFE, 1); push(8'h01, 1);
    expect_frame(0, "R6 frame without crc");
    wcmd(8'h0A);
    wait_idle();
    crc_off = 1'b0;

    // R7: two blocks in one frame
    for (int i = 0; i < 16; i++) push(8'(i * 37 + 5), 1);
    wcmd(8'h08);
    while (fifo_cnt > 4) @(negedge clk);
    chk(tx_active == 1, "R9 active between blocks", tx_active, 1);
    for (int i = 0; i < 6; i++) push(8'(8'hF0 + i), 1);
    expect_frame(1, "R7 two-block frame");
    wcmd(8'h0A);
    wait_idle();

    // R3 block size, R2 ignored command bits
    for (int i = 0; i < 17; i++) push(8'(i + 8'h40), i < 16);
    chk(fifo_cnt == 16, "R3 16-byte block limit", fifo_cnt, 16);
    blk32 = 1'b1;
    for (int i = 0; i < 17; i++) push(8'(i + 8'h80), i < 16);
    chk(fifo_cnt == 32, "R3 32-byte block limit", fifo_cnt, 32);
    wcmd(8'hF4);
    repeat (40) @(negedge clk);
    chk(tx_active == 0, "R2 ignored bits leave transmitter idle", tx_active, 0);
    chk(fifo_cnt == 32, "R2 ignored bits leave fifo", fifo_cnt, 32);
    expect_frame(1, "R3 full 32-byte frame");
    wcmd(8'h0A);
    wait_idle();
    blk32 = 1'b0;

    // R10 underrun
    push(8'h11, 0); push(8'h22, 0);
    exp_len.push_back(-1); exp_tag.push_back("R10 abort");
    wcmd(8'h08);
    wait_idle();
    chk(tx_active == 0, "R10 active clears after abort", tx_active, 0);
    chk(fifo_cnt == 0, "R10 fifo drained", fifo_cnt, 0);

    // R11 transmitter reset mid-frame
    mute = 1'b1;
    for (int i = 0; i < 10; i++) push(8'(i + 1), 0);
    wcmd(8'h0A);
    repeat (100) @(negedge clk);
    wcmd(8'h01);
    chk(tx_active == 0, "R11 active cleared by reset", tx_active, 0);
    chk(fifo_cnt == 0, "R11 fifo cleared by reset", fifo_cnt, 0);
    repeat (200) @(negedge clk);
    mute = 1'b0;
    repeat (80) @(negedge clk);
    push(8'h5A, 1); push(8'hC3, 1);
    expect_frame(1, "R11 frame after transmitter reset");
    wcmd(8'h0A);
    wait_idle();

    // R8 transparent mode on a fresh byte grid
    mute = 1'b1;
    ext_mode = 1'b1;
    do_reset();
    push(8'h00, 0); push(8'hA5, 0); push(8'hFF, 0); push(8'h3C, 0);
    wcmd(8'h0A);
    chk(tx_active == 1, "R9 active in transparent mode", tx_active, 1);
    wait_idle();
    chk(tx_active == 0, "R8 transparent frame ends", tx_active, 0);
    k = -1;
    for (int i = 0; i < raw.size() / 8; i++) if (k < 0 && raw_byte(i) != 8'h7E) k = i;
    chk(k >= 0 && k + 5 <= raw.size() / 8, "R8 raw data found", k, 0);
    if (k >= 0 && k + 5 <= raw.size() / 8) begin
      chk(raw_byte(k) == 8'h00, "R8 raw byte 0", raw_byte(k), 8'h00);
      chk(raw_byte(k+1) == 8'hA5, "R8 raw byte 1", raw_byte(k+1), 8'hA5);
      chk(raw_byte(k+2) == 8'hFF, "R8 raw byte 2 unstuffed", raw_byte(k+2), 8'hFF);
      chk(raw_byte(k+3) == 8'h3C, "R8 raw byte 3", raw_byte(k+3), 8'h3C);
      chk(raw_byte(k+4) == 8'h7E, "R8 no crc after data", raw_byte(k+4), 8'h7E);
    end

    chk(exp_len.size() == 0, "R5 all expected frames seen", exp_len.size(), 0);
    finish_run();
  end
endmodule